// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the read side of a register-controlled I2C bus master. Software loads the 7-bit slave address with the read bit set into the data register and writes a start command. The block then issues a start condition and sends that byte as a transmit frame. Software then turns the block to receive mode and pulls bytes off the bus one at a time. Each read of the data register returns the byte held so far and launches the next 9-clock frame. The first read after the address frame therefore only launches the first reception.

The acknowledge level that the master drives in each received frame comes from a software-owned control bit. To collect the final byte without clocking another frame, software flips the block back to transmit mode before that last read, then writes a stop command. A completion flag, also driven on an interrupt output, rises as SCL rises for the ninth time in each frame. While the flag waits, SCL stays parked low.

Both bus lines are open drain, modelled as pull-down enables, and SDA is sampled through a two-stage synchronizer. A free-running divider sets the SCL timing.

Top module: `i2c_byte_rx_master`

## Requirements
- R1: After reset, CTRL (addr 0) reads 0x01 (bit0 transmit select = 1, bit1 ack control = 0, bit2 busy = 0), STATUS (addr 1) reads 0x00, `irq` is 0, and neither line is pulled.
- R2: A CTRL write with bit2 = 1 and bit3 = 1 while not busy produces a start (SDA falls while SCL is high). It then sends the byte last written to DATA (addr 2) MSB first over 8 clocks and releases SDA in the ninth. Busy reads 1 from the write until the stop completes, and STATUS bit1 holds the SDA level sampled in that ninth clock.
- R3: SCL high and low phases each last HALF_CYC system clocks. SDA changes only while SCL is low, except at start and stop.
- R4: STATUS bit0 (mirrored on `irq`) is set on the clock where SCL rises for the ninth time in a frame. It stays set until a STATUS write with bit0 = 0; a STATUS write with bit0 = 1 leaves it set.
- R5: After a frame ends, SCL stays low and no new clock pulse appears until a receive-mode DATA read or a stop command.
- R6: With CTRL bit0 = 0, a DATA read returns the data register's present content and starts one receive frame. The first such read after the address frame returns stale data.
- R7: Received bits are taken MSB first, and the data register takes the complete byte when the eighth bit is sampled.
- R8: In the ninth clock of a receive frame the master pulls SDA low when CTRL bit1 = 0 and releases it when CTRL bit1 = 1.
- R9: A DATA read with CTRL bit0 = 1 returns the data register and starts no frame.
- R10: A CTRL write with bit2 = 0 and bit3 = 0 while busy produces a stop at the next frame boundary (SDA low, SCL high, then SDA rises). After the stop, busy returns to 0.
- R11: A start command written while busy has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 CTRL, 1 STATUS, 2 DATA |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Frame-complete flag |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The flag and the rising SCL appear on the same system clock, one clock after the line engine enters its high phase. The bench therefore checks the SCL edge count one time step after `irq` rises. SDA settles one clock after SCL falls, and the bench's slave model only changes SDA on SCL falling edges. Phase widths are measured in whole clock periods between bus edges and compared with HALF_CYC. Register reads are sampled between clock edges, before the read strobe takes effect, so a DATA read returns the value held before the frame it launches. Received bytes are compared through a scoreboard queue only after the flag for that frame has been seen.

// File: rtl/i2c_byte_rx_pkg.sv
package i2c_byte_rx_pkg;

    typedef enum logic [2:0] {
        LN_IDLE, LN_START, LN_LOW, LN_HIGH, LN_HOLD, LN_STOP_A, LN_STOP_B, LN_STOP_C
    } line_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam logic [3:0] LAST_BIT = 4'd8;
    localparam logic [3:0] BYTE_BIT = 4'd7;

    // low nibble of a CTRL write
    typedef struct packed {
        logic go_stop;
        logic busy;
        logic nack;
        logic tx;
    } ctrl_wr_t;

    function automatic logic scl_pull_for(line_state_e st);
        case (st)
            LN_LOW, LN_HOLD, LN_STOP_A: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic logic sda_pull_for(line_state_e st, logic [3:0] bitn,
                                          logic frame_tx, logic tx_msb, logic nack);
        case (st)
            LN_START, LN_STOP_A, LN_STOP_B: return 1'b1;
            LN_LOW, LN_HIGH: begin
                if (bitn == LAST_BIT) return frame_tx ? 1'b0 : !nack;
                return frame_tx ? !tx_msb : 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_byte_rx_tick.sv
module i2c_byte_rx_tick #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/i2c_byte_rx_line.sv
module i2c_byte_rx_line
    import i2c_byte_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start_req,
    input  logic       byte_req,
    input  logic       stop_req,
    input  logic [7:0] tx_byte,
    input  logic       nack_sel,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       busy,
    output logic       hold,
    output logic       edge_ok,
    output logic       stop_pend,
    output logic       rx_pend,
    output logic       ninth_rise,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output logic       ack_in
);
    line_state_e st_q;
    logic [3:0]  bit_q;
    logic [7:0]  sh_q;
    logic        frame_tx_q, start_pend_q, rx_pend_q, stop_pend_q;
    logic        scl_q, sda_q, ack_q;
    logic        sync1_q, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= LN_IDLE;
            bit_q        <= '0;
            sh_q         <= '0;
            frame_tx_q   <= 1'b1;
            start_pend_q <= 1'b0;
            rx_pend_q    <= 1'b0;
            stop_pend_q  <= 1'b0;
            scl_q        <= 1'b0;
            sda_q        <= 1'b0;
            ack_q        <= 1'b0;
            sync1_q      <= 1'b1;
            sda_s        <= 1'b1;
        end else begin
            sync1_q <= sda_in;
            sda_s   <= sync1_q;
            if (start_req) start_pend_q <= 1'b1;
            if (byte_req)  rx_pend_q    <= 1'b1;
            if (stop_req)  stop_pend_q  <= 1'b1;
            scl_q <= scl_pull_for(st_q);
            // data moves only under a low clock, or in start/stop phases
            if (scl_q || st_q inside {LN_IDLE, LN_START, LN_STOP_C})
                sda_q <= sda_pull_for(st_q, bit_q, frame_tx_q, sh_q[7], nack_sel);
            if (tick) begin
                case (st_q)
                    LN_IDLE: if (start_pend_q) begin
                        st_q         <= LN_START;
                        start_pend_q <= 1'b0;
                        sh_q         <= tx_byte;
                        frame_tx_q   <= 1'b1;
                    end
                    LN_START: begin
                        st_q  <= LN_LOW;
                        bit_q <= '0;
                    end
                    LN_LOW: st_q <= LN_HIGH;
                    LN_HIGH: begin
                        sh_q <= {sh_q[6:0], sda_s};
                        if (bit_q == LAST_BIT) begin
                            st_q <= LN_HOLD;
                            if (frame_tx_q) ack_q <= sda_s;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            st_q  <= LN_LOW;
                        end
                    end
                    LN_HOLD: begin
                        if (stop_pend_q) begin
                            st_q        <= LN_STOP_A;
                            stop_pend_q <= 1'b0;
                            rx_pend_q   <= 1'b0;
                        end else if (rx_pend_q) begin
                            st_q       <= LN_LOW;
                            rx_pend_q  <= 1'b0;
                            bit_q      <= '0;
                            frame_tx_q <= 1'b0;
                        end
                    end
                    LN_STOP_A: st_q <= LN_STOP_B;
                    LN_STOP_B: st_q <= LN_STOP_C;
                    default:   st_q <= LN_IDLE;
                endcase
            end
        end
    end

    assign scl_pull   = scl_q;
    assign sda_pull   = sda_q;
    assign busy       = (st_q != LN_IDLE) || start_pend_q;
    assign hold       = (st_q == LN_HOLD);
    assign edge_ok    = st_q inside {LN_IDLE, LN_START, LN_STOP_C};
    assign stop_pend  = stop_pend_q;
    assign rx_pend    = rx_pend_q;
    assign ninth_rise = (st_q == LN_HIGH) && (bit_q == LAST_BIT) && scl_q;
    assign rx_load    = tick && (st_q == LN_HIGH) && (bit_q == BYTE_BIT) && !frame_tx_q;
    assign rx_byte    = {sh_q[6:0], sda_s};
    assign ack_in     = ack_q;
endmodule

// File: rtl/i2c_byte_rx_master.sv
module i2c_byte_rx_master
    import i2c_byte_rx_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       sda_in
);
    logic       tick;
    logic       tx_sel_q, nack_sel_q, flag_q;
    logic [7:0] tx_byte_q, data_q;
    logic       eng_busy, eng_hold, eng_edge_ok, eng_stop_pend, eng_rx_pend;
    logic       ninth_rise, rx_load, ack_in;
    logic [7:0] rx_byte;
    ctrl_wr_t   cw;
    logic       wr_ctrl, start_req, stop_req, byte_req;

    assign cw        = ctrl_wr_t'(wdata[3:0]);
    assign wr_ctrl   = wr_en && (addr == ADDR_CTRL);
    assign start_req = wr_ctrl && cw.busy && cw.go_stop && !eng_busy;
    assign stop_req  = wr_ctrl && !cw.busy && !cw.go_stop && eng_busy;
    assign byte_req  = rd_en && (addr == ADDR_DATA) && !tx_sel_q && eng_busy;

    i2c_byte_rx_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    i2c_byte_rx_line u_line (
        .clk(clk), .rst(rst), .tick(tick),
        .start_req(start_req), .byte_req(byte_req), .stop_req(stop_req),
        .tx_byte(tx_byte_q), .nack_sel(nack_sel_q), .sda_in(sda_in),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(eng_busy),
        .hold(eng_hold), .edge_ok(eng_edge_ok), .stop_pend(eng_stop_pend),
        .rx_pend(eng_rx_pend), .ninth_rise(ninth_rise), .rx_load(rx_load),
        .rx_byte(rx_byte), .ack_in(ack_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sel_q   <= 1'b1;
            nack_sel_q <= 1'b0;
            flag_q     <= 1'b0;
            tx_byte_q  <= '0;
            data_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                tx_sel_q   <= cw.tx;
                nack_sel_q <= cw.nack;
            end
            if (wr_en && addr == ADDR_DATA) tx_byte_q <= wdata;
            if (rx_load) data_q <= rx_byte;
            if (ninth_rise)                                     flag_q <= 1'b1;
            else if (wr_en && addr == ADDR_STAT && !wdata[0])   flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {5'b0, eng_busy, nack_sel_q, tx_sel_q};
            ADDR_STAT: rdata = {6'b0, ack_in, flag_q};
            ADDR_DATA: rdata = data_q;
            default:   rdata = 8'h00;
        endcase
    end

    assign irq = flag_q;
endmodule

// File: rtl/i2c_byte_rx_master_chk.sv
module i2c_byte_rx_master_chk
    import i2c_byte_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       irq,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       eng_hold,
    input logic       eng_rx_pend,
    input logic       eng_stop_pend,
    input logic       eng_edge_ok
);
    // R1: reset leaves both lines released and the flag clear
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!scl_pull && !sda_pull && !irq));

    // R4: flag appears together with the ninth SCL rise
    p_flag_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(scl_pull));

    // R4: only a clearing STATUS write removes the flag
    p_flag_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && addr == ADDR_STAT && !wdata[0])) |=> irq);

    // R5: parked clock stays parked without a read or stop
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_hold && !eng_rx_pend && !eng_stop_pend) |=> eng_hold);

    // R3: SDA moves under a high clock only in start/stop phases
    p_sda_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)))
        |-> $past(eng_edge_ok));
endmodule

bind i2c_byte_rx_master i2c_byte_rx_master_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .eng_hold(eng_hold), .eng_rx_pend(eng_rx_pend),
    .eng_stop_pend(eng_stop_pend), .eng_edge_ok(eng_edge_ok)
);

// File: tb/i2c_byte_rx_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_rx_master_tb;
    localparam int HALF = 8;
    localparam logic [6:0] SLV = 7'h52;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, scl_pull, sda_pull;
    logic       slv_pull = 1'b0;
    logic       scl_bus, sda_bus;

    assign scl_bus = ~scl_pull;
    assign sda_bus = ~(sda_pull | slv_pull);

    always #2.5 clk = ~clk;

    i2c_byte_rx_master #(.HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .sda_in(sda_bus)
    );

    int n_checks = 0, n_err = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [7:0] slv_q[$];
    logic       ack_log[$];
    int         phase = 0, k = 0, starts = 0, stops = 0, frame_rises = 0, scl_rises = 0;
    logic [7:0] sl_addr = 8'h00, cur = 8'hFF;
    time        t_rise = 0, t_fall = 0;
    int         last_high = 0, last_low = 0;

    always @(negedge sda_bus) if (scl_bus === 1'b1) begin
        starts++; phase = 1; k = 0; frame_rises = 0; sl_addr = 8'h00; slv_pull = 1'b0;
    end
    always @(posedge sda_bus) if (scl_bus === 1'b1) begin
        stops++; phase = 0; slv_pull = 1'b0;
    end
    always @(posedge scl_bus) begin
        scl_rises++; frame_rises++;
        t_rise = $time; last_low = int'((t_rise - t_fall) / 5);
        if (phase == 1) begin
            k++; if (k <= 8) sl_addr = {sl_addr[6:0], sda_bus};
        end else if (phase == 2) begin
            k++; if (k == 9) ack_log.push_back(sda_bus);
        end
    end
    always @(negedge scl_bus) begin
        t_fall = $time; last_high = int'((t_fall - t_rise) / 5);
        if (phase == 1) begin
            if (k == 8) slv_pull = (sl_addr == {SLV, 1'b1});
            else if (k == 9) begin
                phase = 2; k = 0;
                cur = (slv_q.size() > 0) ? slv_q.pop_front() : 8'hFF;
                slv_pull = ~cur[7];
            end
        end else if (phase == 2) begin
            if (k >= 1 && k <= 7) slv_pull = ~cur[7-k];
            else if (k == 8) slv_pull = 1'b0;
            else if (k == 9) begin
                k = 0;
                if (ack_log.size() > 0 && ack_log[ack_log.size()-1] == 1'b0) begin
                    cur = (slv_q.size() > 0) ? slv_q.pop_front() : 8'hFF;
                    slv_pull = ~cur[7];
                end else begin
                    phase = 0; slv_pull = 1'b0;
                end
            end
        end
    end

    // R4: flag rises with the ninth SCL rise of a frame
    always @(posedge irq) if (!rst) begin
        #1;
        check("R4 flag on ninth rise (count mod 9)", frame_rises % 9, 0);
        check("R4 SCL high when flag rises", scl_bus, 1'b1);
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q[$];
    logic       exp_ack[$];
    logic [7:0] mon_byte;
    event       ev_rx;

    initial forever begin
        @(ev_rx);
        if (exp_q.size() == 0) check("R7 unexpected data read", 1, 0);
        else check("R7 received byte MSB first", mon_byte, exp_q.pop_front());
    end

    // ---------------- register access ----------------
    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic data_read();
        logic [7:0] d;
        reg_rd(2'd2, d);
        mon_byte = d; ->ev_rx;
    endtask

    task automatic wait_irq(input string tag);
        bit seen = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
        if (!seen) check(tag, 0, 1);
    endtask

    task automatic run_read(input int n, input logic [31:0] bytes,
                            input logic [7:0] dummy_exp, input bit first);
        logic [7:0] d;
        int r0, s0;
        for (int i = 0; i < n; i++) begin
            slv_q.push_back(bytes[31-8*i -: 8]);
            exp_q.push_back(bytes[31-8*i -: 8]);
            exp_ack.push_back(i == n - 1);
        end
        reg_wr(2'd2, {SLV, 1'b1});
        reg_wr(2'd0, 8'h0D);
        reg_rd(2'd0, d);
        check("R2 busy set after start write", d, 8'h05);
        wait_irq("R4 flag after address frame");
        check("R2 slave saw address byte", sl_addr, {SLV, 1'b1});
        check("R3 SCL high width", last_high, HALF);
        check("R3 SCL low width", last_low, HALF);
        reg_rd(2'd1, d);
        check("R2 status flag and slave ack", d, 8'h01);
        if (first) begin
            r0 = scl_rises;
            repeat (300) @(negedge clk);
            check("R5 no clocks while parked", scl_rises, r0);
            check("R5 SCL held low", scl_bus, 1'b0);
            reg_wr(2'd1, 8'h01);
            reg_rd(2'd1, d);
            check("R4 write of 1 keeps flag", d, 8'h01);
        end else begin
            s0 = starts;
            reg_wr(2'd0, 8'h0D);
            repeat (100) @(negedge clk);
            check("R11 start while busy ignored", starts, s0);
        end
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd1, d);
        check("R4 write of 0 clears flag", d, 8'h00);
        check("R4 irq low after clear", irq, 1'b0);
        reg_wr(2'd0, (n == 1) ? 8'h06 : 8'h04);
        reg_rd(2'd2, d);
        check("R6 dummy read returns stale data", d, dummy_exp);
        for (int i = 0; i < n; i++) begin
            wait_irq("R6 flag after receive frame");
            reg_wr(2'd1, 8'h00);
            if (i == n - 1) begin
                reg_wr(2'd0, 8'h07);
                r0 = scl_rises;
                data_read();
                repeat (300) @(negedge clk);
                check("R9 transmit-mode read starts no frame", scl_rises, r0);
            end else begin
                if (i == n - 2) reg_wr(2'd0, 8'h06);
                data_read();
            end
        end
        s0 = stops;
        reg_wr(2'd0, 8'h03);
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (stops != s0 && !sda_pull && !scl_pull) break;
        end
        repeat (3 * HALF) @(negedge clk);
        check("R10 stop seen on bus", stops, s0 + 1);
        reg_rd(2'd0, d);
        check("R10 busy cleared after stop", d, 8'h03);
        check("R10 lines released", {scl_bus, sda_bus}, 2'b11);
        while (exp_ack.size() > 0) begin
            if (ack_log.size() == 0) check("R8 missing ack slot", 0, 1);
            else check("R8 master ack level", ack_log.pop_front(), exp_ack.pop_front());
            void'(exp_ack.size());
        end
    endtask

    // ---------------- main ----------------
    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        starts = 0; stops = 0;
        reg_rd(2'd0, d);
        check("R1 CTRL reset value", d, 8'h01);
        reg_rd(2'd1, d);
        check("R1 STATUS reset value", d, 8'h00);
        check("R1 lines released and irq low", {scl_bus, sda_bus, irq}, 3'b110);
        run_read(3, 32'h3CC35A00, 8'h00, 1'b1);
        run_read(1, 32'h96000000, 8'h5A, 1'b0);
        check("R7 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule